// File: doc/BRIEF.md
# Three-Region Memory Address Translator

This block maps a 16-bit logical memory address onto a 20-bit physical address, giving a processor with a 64 KB view access to a 1 MB memory. The logical space is cut on 4 KB page lines into three windows. The lowest window is a fixed common window that maps one to one. The middle window is a bank whose physical placement is chosen by a bank base register. The top window is a second common window placed by its own base register. One register holds both page boundaries.

Translation is combinational from the logical address and the current register contents. The cycle-type input marks I/O cycles, and I/O addresses leave the block unchanged. Software programs the three registers through a simple write port (select, data, strobe) and reads them back through a separate read-select port.

Top module: `mmu_bank_xlate`

## Requirements
- R1: After reset, the boundary register reads 0xF0 (upper-window start page 0xF in bits 7:4, bank start page 0x0 in bits 3:0), and both base registers read 0x00.
- R2: With reset register values, every memory address translates to itself zero-extended to 20 bits.
- R3: A memory address whose page (logical bits 15:12) is below the bank start page maps to itself with physical bits 19:16 zero.
- R4: A memory address whose page is not below the bank start page and is at or above the upper-window start page maps to logical + (common base × 4096).
- R5: A memory address whose page is at or above the bank start page and below the upper-window start page maps to logical + (bank base × 4096).
- R6: The lower-window test has priority: when the upper-window start is at or below the bank start, pages below the bank start still map one to one.
- R7: When io_cycle is 1, the physical address is the logical address zero-extended, whatever the register contents.
- R8: All sums are taken modulo 2^20 (carries out of bit 19 are dropped), and logical bits 11:0 always appear unchanged in physical bits 11:0.
- R9: Register select codes are 0 = boundary, 1 = bank base, 2 = common base. A write with wr_en high is captured at the clock edge, changes the translation of any address presented afterwards, and reads back through rd_data; without wr_en no register changes.
- R10: Select code 3 addresses no register: a write to it changes nothing, and reading it returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the register writes |
| rst_n | input | 1 | Active-low synchronous reset |
| log_addr | input | 16 | Logical address |
| io_cycle | input | 1 | 1 = I/O cycle (no translation), 0 = memory cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Register write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 8 | Register read data |
| phys_addr | output | 20 | Translated physical address |

## Verification
Directed addresses sit on each side of both page boundaries (last page of the lower window, first bank page, last bank page, first upper page), which separates an off-by-one in either comparison from a wrong base choice. Base values near 0xFF combined with high logical pages force carries past bit 19 and show whether the sum wraps. A boundary with the upper start below the bank start tells whether the lower-window test wins. Random register writes mixed with random addresses and occasional I/O cycles compare every output against a bench model.

// File: rtl/mmu_bank_pkg.sv
package mmu_bank_pkg;

  typedef enum logic [1:0] {
    RGN_LOWER = 2'd0,
    RGN_BANK  = 2'd1,
    RGN_UPPER = 2'd2,
    RGN_PASS  = 2'd3
  } rgn_e;

  typedef enum logic [1:0] {
    SEL_BOUND = 2'd0,
    SEL_BANKB = 2'd1,
    SEL_COMB  = 2'd2,
    SEL_NONE  = 2'd3
  } regsel_e;

  localparam int NUM_BASES = 2;

endpackage

// File: rtl/mmu_cfg_regs.sv
module mmu_cfg_regs
  import mmu_bank_pkg::*;
#(
  parameter int FLD_W  = 4,
  parameter int BASE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [1:0]           rd_sel,
  output logic [DATA_W-1:0]    rd_data,
  output logic [2*FLD_W-1:0]   bnd_q,
  output logic [BASE_W-1:0]    bank_base,
  output logic [BASE_W-1:0]    com_base
);
  localparam int BND_W = 2 * FLD_W;
  localparam logic [BND_W-1:0] BND_RST = {{FLD_W{1'b1}}, {FLD_W{1'b0}}};

  logic bnd_we;
  assign bnd_we = wr_en && (wr_sel == SEL_BOUND);

  always_ff @(posedge clk) begin
    if (!rst_n)      bnd_q <= BND_RST;
    else if (bnd_we) bnd_q <= wr_data[BND_W-1:0];
  end

  logic [BASE_W-1:0] base_q [NUM_BASES];

  for (genvar g = 0; g < NUM_BASES; g++) begin : g_base
    localparam logic [1:0] CODE = 2'(g + 1);
    logic base_we;
    assign base_we = wr_en && (wr_sel == CODE);
    always_ff @(posedge clk) begin
      if (!rst_n)       base_q[g] <= '0;
      else if (base_we) base_q[g] <= wr_data[BASE_W-1:0];
    end
  end

  assign bank_base = base_q[0];
  assign com_base  = base_q[1];

  always_comb begin
    case (regsel_e'(rd_sel))
      SEL_BOUND: rd_data = DATA_W'(bnd_q);
      SEL_BANKB: rd_data = DATA_W'(bank_base);
      SEL_COMB:  rd_data = DATA_W'(com_base);
      default:   rd_data = '0;
    endcase
  end

endmodule

// File: rtl/mmu_region_sel.sv
module mmu_region_sel
  import mmu_bank_pkg::*;
#(
  parameter int FLD_W = 4
) (
  input  logic [FLD_W-1:0] page,
  input  logic [FLD_W-1:0] bank_start,
  input  logic [FLD_W-1:0] upper_start,
  input  logic             io_cycle,
  output logic             below_bank,
  output logic             at_upper,
  output rgn_e             rgn
);
  assign below_bank = page < bank_start;
  assign at_upper   = page >= upper_start;

  always_comb begin
    if (io_cycle)        rgn = RGN_PASS;
    else if (below_bank) rgn = RGN_LOWER;
    else if (at_upper)   rgn = RGN_UPPER;
    else                 rgn = RGN_BANK;
  end

endmodule

// File: rtl/mmu_reloc_add.sv
module mmu_reloc_add
  import mmu_bank_pkg::*;
#(
  parameter int LOG_W   = 16,
  parameter int PHYS_W  = 20,
  parameter int PAGE_SH = 12
) (
  input  logic [LOG_W-1:0]          log_addr,
  input  logic [PHYS_W-PAGE_SH-1:0] base,
  input  rgn_e                      rgn,
  output logic [PHYS_W-1:0]         phys_addr
);
  localparam int BASE_W = PHYS_W - PAGE_SH;

  function automatic logic [PHYS_W-1:0] widen(input logic [LOG_W-1:0] a);
    return {{(PHYS_W - LOG_W){1'b0}}, a};
  endfunction

  function automatic logic [PHYS_W-1:0] relocate(input logic [LOG_W-1:0] a,
                                                 input logic [BASE_W-1:0] b);
    logic [PHYS_W-1:0] offs;
    offs = {b, {PAGE_SH{1'b0}}};
    return widen(a) + offs;
  endfunction

  logic apply_base;
  assign apply_base = (rgn == RGN_BANK) || (rgn == RGN_UPPER);

  assign phys_addr = apply_base ? relocate(log_addr, base) : widen(log_addr);

endmodule

// File: rtl/mmu_bank_xlate.sv
module mmu_bank_xlate
  import mmu_bank_pkg::*;
#(
  parameter int LOG_W   = 16,
  parameter int PHYS_W  = 20,
  parameter int PAGE_SH = 12,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOG_W-1:0]  log_addr,
  input  logic              io_cycle,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [PHYS_W-1:0] phys_addr
);
  localparam int FLD_W  = LOG_W - PAGE_SH;
  localparam int BASE_W = PHYS_W - PAGE_SH;

  logic [2*FLD_W-1:0] bnd_q;
  logic [BASE_W-1:0]  bank_base;
  logic [BASE_W-1:0]  com_base;
  logic [FLD_W-1:0]   page;
  logic [FLD_W-1:0]   bank_start;
  logic [FLD_W-1:0]   upper_start;
  logic               below_bank;
  logic               at_upper;
  rgn_e               rgn;
  logic [BASE_W-1:0]  base_pick;

  mmu_cfg_regs #(
    .FLD_W (FLD_W),
    .BASE_W(BASE_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .bnd_q    (bnd_q),
    .bank_base(bank_base),
    .com_base (com_base)
  );

  assign page        = log_addr[LOG_W-1:PAGE_SH];
  assign bank_start  = bnd_q[FLD_W-1:0];
  assign upper_start = bnd_q[2*FLD_W-1:FLD_W];

  mmu_region_sel #(.FLD_W(FLD_W)) u_sel (
    .page       (page),
    .bank_start (bank_start),
    .upper_start(upper_start),
    .io_cycle   (io_cycle),
    .below_bank (below_bank),
    .at_upper   (at_upper),
    .rgn        (rgn)
  );

  assign base_pick = (rgn == RGN_UPPER) ? com_base : bank_base;

  mmu_reloc_add #(
    .LOG_W  (LOG_W),
    .PHYS_W (PHYS_W),
    .PAGE_SH(PAGE_SH)
  ) u_add (
    .log_addr (log_addr),
    .base     (base_pick),
    .rgn      (rgn),
    .phys_addr(phys_addr)
  );

endmodule

// File: rtl/mmu_bank_xlate_chk.sv
module mmu_bank_xlate_chk
  import mmu_bank_pkg::*;
#(
  parameter int LOG_W   = 16,
  parameter int PHYS_W  = 20,
  parameter int PAGE_SH = 12,
  parameter int DATA_W  = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [LOG_W-1:0]            log_addr,
  input logic                        io_cycle,
  input logic                        wr_en,
  input logic [1:0]                  wr_sel,
  input logic [DATA_W-1:0]           wr_data,
  input logic [PHYS_W-1:0]           phys_addr,
  input rgn_e                        rgn,
  input logic [2*(LOG_W-PAGE_SH)-1:0] bnd_q,
  input logic [PHYS_W-PAGE_SH-1:0]   bank_base,
  input logic [PHYS_W-PAGE_SH-1:0]   com_base
);
  localparam int FLD_W = LOG_W - PAGE_SH;
  localparam int BASE_W = PHYS_W - PAGE_SH;

  logic [FLD_W-1:0] pg;
  assign pg = log_addr[LOG_W-1:PAGE_SH];

  AST_IO_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    io_cycle |-> rgn == RGN_PASS); // R7

  AST_IO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    io_cycle |-> (phys_addr[PHYS_W-1:LOG_W] == '0 && phys_addr[LOG_W-1:0] == log_addr)); // R7

  AST_LOWER_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    rgn == RGN_LOWER |-> (phys_addr[PHYS_W-1:LOG_W] == '0 && phys_addr[LOG_W-1:0] == log_addr)); // R3

  AST_LOWER_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_cycle && pg < bnd_q[FLD_W-1:0]) |-> rgn == RGN_LOWER); // R6

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[PAGE_SH-1:0] == log_addr[PAGE_SH-1:0]); // R8

  AST_BOUND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_BOUND) |=> bnd_q == $past(wr_data[2*FLD_W-1:0])); // R9

  AST_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_BANKB) |=> bank_base == $past(wr_data[BASE_W-1:0])); // R9

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(bnd_q) && $stable(bank_base) && $stable(com_base))); // R9

  AST_RSVD_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_NONE) |=> ($stable(bnd_q) && $stable(bank_base) && $stable(com_base))); // R10

endmodule

bind mmu_bank_xlate mmu_bank_xlate_chk #(
  .LOG_W  (LOG_W),
  .PHYS_W (PHYS_W),
  .PAGE_SH(PAGE_SH),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .log_addr (log_addr),
  .io_cycle (io_cycle),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .phys_addr(phys_addr),
  .rgn      (rgn),
  .bnd_q    (bnd_q),
  .bank_base(bank_base),
  .com_base (com_base)
);

// File: tb/mmu_bank_xlate_test.sv
module mmu_bank_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] log_addr = '0;
  logic        io_cycle = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [7:0]  rd_data;
  logic [19:0] phys_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_bnd  = 8'hF0;
  logic [7:0] m_bank = 8'h00;
  logic [7:0] m_com  = 8'h00;

  always #2 clk = ~clk;

  mmu_bank_xlate uut (
    .clk(clk), .rst_n(rst_n), .log_addr(log_addr), .io_cycle(io_cycle),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .phys_addr(phys_addr)
  );

  function automatic logic [19:0] model(input logic [15:0] a, input logic io);
    int unsigned pg, lo, hi, sum;
    pg = a >> 12;
    lo = m_bnd & 8'h0F;
    hi = m_bnd >> 4;
    if (io || pg < lo) return {4'h0, a};
    if (pg >= hi) sum = a + (m_com * 4096);
    else          sum = a + (m_bank * 4096);
    return sum[19:0];
  endfunction

  function automatic string rtag(input logic [15:0] a, input logic io);
    int unsigned pg;
    pg = a >> 12;
    if (io) return "R7";
    if (pg < (m_bnd & 8'h0F)) return "R3";
    if (pg >= (m_bnd >> 4)) return "R4";
    return "R5";
  endfunction

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (s)
      2'd0: m_bnd = d;
      2'd1: m_bank = d;
      2'd2: m_com = d;
      default: ;
    endcase
  endtask

  task automatic chk_addr(input logic [15:0] a, input logic io, input string tag);
    logic [19:0] e;
    log_addr = a; io_cycle = io;
    #1;
    e = model(a, io);
    n_chk++;
    if (phys_addr !== e) begin
      n_bad++;
      $display("FAIL %s addr=%h io=%0d actual=%h expected=%h", tag, a, io, phys_addr, e);
    end
  endtask

  task automatic chk_rd(input logic [1:0] s, input logic [7:0] e, input string tag);
    rd_sel = s;
    #1;
    n_chk++;
    if (rd_data !== e) begin
      n_bad++;
      $display("FAIL %s rd_sel=%0d actual=%h expected=%h", tag, s, rd_data, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5E_ED01));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values, R10 reserved reads zero
    chk_rd(2'd0, 8'hF0, "R1");
    chk_rd(2'd1, 8'h00, "R1");
    chk_rd(2'd2, 8'h00, "R1");
    chk_rd(2'd3, 8'h00, "R10");

    // R2 identity after reset
    chk_addr(16'h0000, 1'b0, "R2");
    chk_addr(16'hABCD, 1'b0, "R2");
    chk_addr(16'hF123, 1'b0, "R2");
    chk_addr(16'hFFFF, 1'b0, "R2");

    // R9 program: upper start 8, bank start 4
    wr(2'd0, 8'h84);
    wr(2'd1, 8'h30);
    wr(2'd2, 8'h70);
    chk_rd(2'd0, 8'h84, "R9");
    chk_rd(2'd1, 8'h30, "R9");
    chk_rd(2'd2, 8'h70, "R9");

    // boundaries
    chk_addr(16'h3FFF, 1'b0, "R3");
    chk_addr(16'h4000, 1'b0, "R5");
    chk_addr(16'h7FFF, 1'b0, "R5");
    chk_addr(16'h8000, 1'b0, "R4");
    chk_addr(16'hFFFF, 1'b0, "R4");
    chk_addr(16'h8000, 1'b1, "R7");
    chk_addr(16'h4567, 1'b1, "R7");

    // R8 wraparound
    wr(2'd1, 8'hFF);
    chk_addr(16'h4123, 1'b0, "R8");
    wr(2'd2, 8'hF9);
    chk_addr(16'hC000, 1'b0, "R8");
    chk_addr(16'hFFFF, 1'b0, "R8");

    // R6 priority: upper start 2 below bank start 5
    wr(2'd0, 8'h25);
    chk_addr(16'h3000, 1'b0, "R6");
    chk_addr(16'h4FFF, 1'b0, "R6");
    chk_addr(16'h5000, 1'b0, "R6");
    chk_addr(16'h1000, 1'b0, "R6");

    // R10 reserved write has no effect
    wr(2'd3, 8'hAA);
    chk_rd(2'd0, 8'h25, "R10");
    chk_rd(2'd1, 8'hFF, "R10");
    chk_rd(2'd2, 8'hF9, "R10");
    chk_rd(2'd3, 8'h00, "R10");
    chk_addr(16'h5000, 1'b0, "R10");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic io;
      if ($urandom % 4 == 0) wr(2'($urandom), 8'($urandom));
      a = 16'($urandom);
      io = ($urandom % 8) == 0;
      chk_addr(a, io, rtag(a, io));
      if (i % 50 == 0) chk_rd(2'd0, m_bnd, "R9");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule